// File: doc/BRIEF.md
# Two-Level Round-Robin Lock Token Tree

This block hands one shared lock to many cores through a two-level arbitration tree. Each core raises a level request flag when it wants the lock. When the lock is handed to it, the core sees a single-cycle grant pulse on its own output line. It gives the lock back with a single-cycle drop pulse. Cores are split into equal groups. A local manager per group arbitrates among its own cores, and one root manager arbitrates among the groups that have at least one request flag raised.

The root hands its token to a group. That group's local manager then makes one round-robin lap over its cores, starting from its stored pointer. On each drop from the current holder, the lock moves straight to the next requesting core further along the lap, and the root is not involved. When the lap has no requester left ahead of the holder, the manager returns the token to the root. It also moves its pointer to one past the last holder. The root then serves the next group in round-robin order, so a group that keeps requesting cannot starve the others.

The reset is asynchronous and active-low. It is expected to be released synchronously to `clk` upstream. Group size and group count must be powers of two, at least 2.

Top module: `tok_lock_tree`

## Requirements
- R1: At most one bit of `grant_o` is high in any cycle, each grant is a one-cycle pulse, and no new grant appears while the core that last received a grant has not dropped the lock.
- R2: While `rst_n` is low and after it is released, `grant_o` is all zero, the token sits at the root, and every round-robin pointer (root and local) is at index 0.
- R3: The root serves only groups whose request flag (the OR of that group's core requests) is set. It chooses the first such group at or after its pointer, wrapping, and then moves its pointer to one past the chosen group.
- R4: With the root idle, a request first sampled on clock edge E makes that core's grant pulse appear in the cycle after edge E+1, two cycles after the request is applied.
- R5: A local manager that receives the token grants the first requesting core of its group at or after its pointer, wrapping. Group-local index i is core `g*GROUP_SIZE+i`.
- R6: When the holder drops the lock and a requester lies ahead of it in the current lap, that requester's grant appears in the cycle right after the drop.
- R7: When the holder drops and no requester lies ahead in the lap, the local manager returns the token to the root and sets its pointer to one past the holder. The next group's chosen core is granted three cycles after the drop cycle, or never if no group requests.
- R8: A request raised in a group during its lap is served in that lap only if it lies ahead of the current holder in lap order (offset from the lap's start index). Otherwise it waits for the group's next turn from the root.
- R9: A drop pulse from a core that does not hold the lock changes nothing.
- R10: A grant is given only to a core whose request flag was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| want_i | input | NUM_GROUPS*GROUP_SIZE (32) | Per-core request flags, level |
| drop_i | input | NUM_GROUPS*GROUP_SIZE (32) | Per-core release pulse, one cycle |
| grant_o | output | NUM_GROUPS*GROUP_SIZE (32) | Per-core lock grant pulse, one cycle |

## Verification
Four properties are checked on every cycle: mutual exclusion of the lock, grants only to cores that were requesting, at most one group token at the root, and a group token always being followed by either a core grant or an immediate return. The order in which cores and groups are chosen, the one-, two- and three-cycle handoff latencies, and the handling of late requests and stray drops depend on pointer history. Only the bench's directed scenarios show these, through their expected grant index and delay.

// File: rtl/lkt_pkg.sv
package lkt_pkg;

  // Local manager: either waiting for the root token or holding it for a core.
  typedef enum logic {
    LM_IDLE = 1'b0,
    LM_HOLD = 1'b1
  } lm_state_e;

endpackage

// File: rtl/lkt_rr_pick.sv
// First set bit at or after 'start_i', wrapping around. N must be a power of two.
module lkt_rr_pick #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0]         cand_i,
  input  logic [$clog2(N)-1:0] start_i,
  output logic                 found_o,
  output logic [$clog2(N)-1:0] idx_o
);
  localparam int unsigned IW = $clog2(N);

  logic [IW-1:0] probe;

  always_comb begin
    found_o = 1'b0;
    idx_o   = start_i;
    probe   = start_i;
    for (int k = 0; k < N; k++) begin
      probe = start_i + IW'(k);
      if (!found_o && cand_i[probe]) begin
        found_o = 1'b1;
        idx_o   = probe;
      end
    end
  end

endmodule

// File: rtl/lkt_local_mgr.sv
module lkt_local_mgr
  import lkt_pkg::*;
#(
  parameter int unsigned SIZE = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SIZE-1:0] want_i,
  input  logic [SIZE-1:0] drop_i,
  input  logic            tok_i,
  output logic [SIZE-1:0] grant_o,
  output logic            done_o
);
  localparam int unsigned IW = $clog2(SIZE);

  lm_state_e       state_q, state_d;
  logic [IW-1:0]   ptr_q, ptr_d;
  logic [IW-1:0]   base_q, base_d;
  logic [IW-1:0]   hold_q, hold_d;
  logic [SIZE-1:0] grant_q, grant_d;
  logic            done_q, done_d;

  logic            start_ev, drop_ev, upd_en;
  logic [IW-1:0]   hold_off, scan_start, pick_idx;
  logic [SIZE-1:0] elig;
  logic            pick_found;

  assign start_ev   = tok_i && (state_q == LM_IDLE);
  assign drop_ev    = (state_q == LM_HOLD) && drop_i[hold_q];
  assign upd_en     = start_ev || drop_ev;
  assign hold_off   = hold_q - base_q;
  assign scan_start = start_ev ? ptr_q : base_q;

  // On a new lap every requester is eligible; on a handoff only those
  // whose lap offset lies beyond the current holder.
  always_comb begin
    for (int i = 0; i < SIZE; i++) begin
      elig[i] = want_i[i] && (start_ev || ((IW'(i) - base_q) > hold_off));
    end
  end

  lkt_rr_pick #(.N(SIZE)) u_pick (
    .cand_i  (elig),
    .start_i (scan_start),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    base_d  = base_q;
    hold_d  = hold_q;
    grant_d = '0;
    done_d  = 1'b0;
    if (start_ev) begin
      base_d = ptr_q;
      if (pick_found) begin
        state_d          = LM_HOLD;
        hold_d           = pick_idx;
        grant_d[pick_idx] = 1'b1;
      end else begin
        done_d = 1'b1;
      end
    end else if (drop_ev) begin
      if (pick_found) begin
        hold_d            = pick_idx;
        grant_d[pick_idx] = 1'b1;
      end else begin
        state_d = LM_IDLE;
        ptr_d   = hold_q + IW'(1);
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LM_IDLE;
      ptr_q   <= '0;
      base_q  <= '0;
      hold_q  <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      base_q  <= base_d;
      hold_q  <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      done_q  <= 1'b0;
    end else begin
      grant_q <= grant_d;
      done_q  <= done_d;
    end
  end

  assign grant_o = grant_q;
  assign done_o  = done_q;

endmodule

// File: rtl/lkt_root_mgr.sv
module lkt_root_mgr #(
  parameter int unsigned GROUPS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GROUPS-1:0] grp_want_i,
  input  logic [GROUPS-1:0] grp_done_i,
  output logic [GROUPS-1:0] grp_tok_o
);
  localparam int unsigned GW = $clog2(GROUPS);

  logic              busy_q, busy_d;
  logic [GW-1:0]     own_q, own_d;
  logic [GW-1:0]     ptr_q, ptr_d;
  logic [GROUPS-1:0] tok_q, tok_d;
  logic              free, pick_found;
  logic [GW-1:0]     pick_idx;

  // Done pulses from groups other than the owner are ignored.
  assign free = !busy_q || grp_done_i[own_q];

  lkt_rr_pick #(.N(GROUPS)) u_pick (
    .cand_i  (grp_want_i),
    .start_i (ptr_q),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  always_comb begin
    busy_d = busy_q;
    own_d  = own_q;
    ptr_d  = ptr_q;
    tok_d  = '0;
    if (free) begin
      busy_d = pick_found;
      if (pick_found) begin
        own_d           = pick_idx;
        ptr_d           = pick_idx + GW'(1);
        tok_d[pick_idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      own_q  <= '0;
      ptr_q  <= '0;
    end else if (free) begin
      busy_q <= busy_d;
      own_q  <= own_d;
      ptr_q  <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tok_q <= '0;
    else        tok_q <= tok_d;
  end

  assign grp_tok_o = tok_q;

endmodule

// File: rtl/tok_lock_tree.sv
module tok_lock_tree #(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned GROUP_SIZE = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_GROUPS*GROUP_SIZE-1:0] want_i,
  input  logic [NUM_GROUPS*GROUP_SIZE-1:0] drop_i,
  output logic [NUM_GROUPS*GROUP_SIZE-1:0] grant_o
);
  logic [NUM_GROUPS-1:0] grp_want;
  logic [NUM_GROUPS-1:0] grp_tok;
  logic [NUM_GROUPS-1:0] grp_done;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    assign grp_want[g] = |want_i[g*GROUP_SIZE +: GROUP_SIZE];

    lkt_local_mgr #(.SIZE(GROUP_SIZE)) u_local (
      .clk     (clk),
      .rst_n   (rst_n),
      .want_i  (want_i[g*GROUP_SIZE +: GROUP_SIZE]),
      .drop_i  (drop_i[g*GROUP_SIZE +: GROUP_SIZE]),
      .tok_i   (grp_tok[g]),
      .grant_o (grant_o[g*GROUP_SIZE +: GROUP_SIZE]),
      .done_o  (grp_done[g])
    );
  end

  lkt_root_mgr #(.GROUPS(NUM_GROUPS)) u_root (
    .clk        (clk),
    .rst_n      (rst_n),
    .grp_want_i (grp_want),
    .grp_done_i (grp_done),
    .grp_tok_o  (grp_tok)
  );

endmodule

// File: rtl/tok_lock_tree_chk.sv
module tok_lock_tree_chk #(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned GROUP_SIZE = 8
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_GROUPS*GROUP_SIZE-1:0] want_i,
  input logic [NUM_GROUPS*GROUP_SIZE-1:0] drop_i,
  input logic [NUM_GROUPS*GROUP_SIZE-1:0] grant_o,
  input logic [NUM_GROUPS-1:0]            grp_want,
  input logic [NUM_GROUPS-1:0]            grp_tok,
  input logic [NUM_GROUPS-1:0]            grp_done
);
  localparam int unsigned NC = NUM_GROUPS * GROUP_SIZE;
  localparam int unsigned CW = $clog2(NC);

  logic          held_q;
  logic [CW-1:0] owner_q;
  logic [CW-1:0] grant_idx;

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < NC; i++) begin
      if (grant_o[i]) grant_idx = CW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      owner_q <= '0;
    end else if (|grant_o) begin
      held_q  <= 1'b1;
      owner_q <= grant_idx;
    end else if (held_q && drop_i[owner_q]) begin
      held_q  <= 1'b0;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R1

  AST_NO_GRANT_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    held_q |-> (grant_o == '0)); // R1

  AST_GRANT_HAD_WANT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0) |-> ((grant_o & ~$past(want_i)) == '0)); // R10

  AST_ROOT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_tok)); // R3

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    AST_ROOT_TOK_HAD_WANT: assert property (@(posedge clk) disable iff (!rst_n)
      grp_tok[g] |-> $past(grp_want[g])); // R3

    AST_TOK_REACHES_CORE: assert property (@(posedge clk) disable iff (!rst_n)
      grp_tok[g] |=> ((|grant_o[g*GROUP_SIZE +: GROUP_SIZE]) || grp_done[g])); // R4
  end

endmodule

bind tok_lock_tree tok_lock_tree_chk #(
  .NUM_GROUPS (NUM_GROUPS),
  .GROUP_SIZE (GROUP_SIZE)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .want_i   (want_i),
  .drop_i   (drop_i),
  .grant_o  (grant_o),
  .grp_want (grp_want),
  .grp_tok  (grp_tok),
  .grp_done (grp_done)
);

// File: tb/tok_lock_tree_tb_top.sv
`timescale 1ns/1ps
module tok_lock_tree_tb_top;
  localparam int NG = 4;
  localparam int GS = 8;
  localparam int NC = NG * GS;

  logic          clk;
  logic          rst_n;
  logic [NC-1:0] want_i;
  logic [NC-1:0] drop_i;
  logic [NC-1:0] grant_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  tok_lock_tree #(.NUM_GROUPS(NG), .GROUP_SIZE(GS)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .want_i  (want_i),
    .drop_i  (drop_i),
    .grant_o (grant_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [NC-1:0] b(input int k);
    return NC'(1) << k;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Apply stimulus at a falling edge, then watch for the first grant.
  // exp_idx < 0 means no grant may appear within the window.
  task automatic step(input logic [NC-1:0] set_m, input logic [NC-1:0] clr_m,
                      input logic [NC-1:0] drop_m, input int exp_idx,
                      input int exp_dly, input string tag);
    int n0;
    int seen_idx;
    int seen_dly;
    logic [NC-1:0] seen_vec;
    @(negedge clk);
    want_i = (want_i | set_m) & ~clr_m;
    drop_i = drop_m;
    n0 = cyc;
    seen_idx = -1;
    seen_dly = 0;
    seen_vec = '0;
    for (int k = 0; k < 8 && seen_idx < 0; k++) begin
      @(negedge clk);
      drop_i = '0;
      if (grant_o != '0) begin
        seen_vec = grant_o;
        seen_dly = cyc - n0;
        for (int i = NC - 1; i >= 0; i--) if (grant_o[i]) seen_idx = i;
      end
    end
    if (exp_idx < 0) begin
      check(seen_idx < 0, {tag, " no grant"}, seen_idx, -1);
    end else begin
      check(seen_vec == b(exp_idx), {tag, " grant index"}, seen_idx, exp_idx);
      check(seen_dly == exp_dly, {tag, " grant delay"}, seen_dly, exp_dly);
    end
  endtask

  task automatic t_reset;
    rst_n  = 1'b0;
    want_i = '0;
    drop_i = '0;
    repeat (3) @(negedge clk);
    check(grant_o == '0, "R2 grant during reset", int'(|grant_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(grant_o == '0, "R2 grant after reset", int'(|grant_o), 0);
    step('0, '0, '0, -1, 0, "R10 idle");
  endtask

  task automatic t_single;
    step(b(3), '0, '0, 3, 2, "R4 R2 first grant");
    step('0, b(3), b(3), -1, 0, "R7 return with no requester");
  endtask

  task automatic t_local_chain;
    step(b(9) | b(12) | b(14), '0, '0, 9, 2, "R5 lap start");
    step('0, b(9), b(9), 12, 1, "R6 local handoff");
    step('0, b(12), b(12), 14, 1, "R6 local handoff");
    step('0, b(14), b(14), -1, 0, "R7 lap end");
  endtask

  task automatic t_cross_group;
    step(b(20) | b(30) | b(1), '0, '0, 20, 2, "R3 root order");
    step('0, b(20), b(20), 30, 3, "R7 group switch");
    step('0, b(30), b(30), 1, 3, "R3 R5 root wrap, local pointer");
    step('0, b(1), b(1), -1, 0, "R7 lap end");
  endtask

  task automatic t_late_request;
    step(b(22), '0, '0, 22, 2, "R5 lap from pointer");
    step(b(21) | b(23), '0, '0, -1, 0, "R1 no grant while held");
    step('0, b(22), b(22), 23, 1, "R8 ahead served in lap");
    step('0, b(23), b(23), 21, 3, "R8 behind waits next turn");
    step('0, b(21), b(21), -1, 0, "R7 lap end");
  endtask

  task automatic t_stray_drop;
    step(b(26) | b(27), '0, '0, 26, 2, "R5 lap from pointer");
    step('0, '0, b(27) | b(5), -1, 0, "R9 stray drop ignored");
    step('0, b(26), b(26), 27, 1, "R9 holder still owns");
    step('0, b(27), b(27), -1, 0, "R7 lap end");
  endtask

  task automatic t_all_groups;
    step(b(0) | b(8) | b(16) | b(24), '0, '0, 0, 2, "R3 all groups");
    step('0, b(0), b(0), 8, 3, "R3 next group");
    step('0, b(8), b(8), 16, 3, "R3 next group");
    step('0, b(16), b(16), 24, 3, "R3 next group");
    step('0, b(24), b(24), -1, 0, "R7 lap end");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_local_chain();
    t_cross_group();
    t_late_request();
    t_stray_drop();
    t_all_groups();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule